// File: doc/BRIEF.md
# Shared-Bus Arbiter with Fixed Bridge Priority, Rotation and Parking

This block decides which of up to four masters may drive a shared synchronous multiprocessor bus. Master 0 is the I/O bridge port. It wins every arbitration in which it is requesting, so that network traffic sees short latency. Masters 1 to 3 are processors and take turns in rotating order. Each master has its own request line and its own grant line. All masters share one active-low busy line, which the owner holds low while it uses the bus.

The grant is a registered one-hot vector. Ownership moves only at a clock edge where busy is sampled high (released). The old grant drops and the new grant rises at that same edge. When nobody is requesting, the grant stays parked on the last owner. That owner may then start a new transfer without arbitrating again. Once a new grant has been issued, it is held until the grantee has taken the bus. The grantee shows this by pulling busy low.

Top module: `hybrid_bus_arbiter`

## Requirements
- R1: Reset is synchronous and active low. After reset the grant is 4'b0001 (parked on bridge master 0), and the rotation pointer selects master 1 first among the processors.
- R2: Exactly one bit of `gnt_o` is high in every cycle after reset. Bit k of `gnt_o` is the grant for master k.
- R3: At an edge where `bus_busy_ni` is sampled low, `gnt_o` does not change.
- R4: At an arbitration point, master 0 (`req_i[0]`) wins whenever it requests. An arbitration point is either an edge where the bus is idle and parked, or the edge where the owner's release of busy is sampled.
- R5: Among masters 1..3 the search starts at the master after the processor granted last, wrapping from 3 to 1.
- R6: A grant to master 0 leaves the rotation pointer unchanged.
- R7: At an edge where `bus_busy_ni` is high and no `req_i` bit is set, `gnt_o` keeps its value (parking).
- R8: After the grant moves to a new master, it is held with no re-arbitration, even against master 0, until `bus_busy_ni` is sampled low.
- R9: At the first edge where the owner's release (`bus_busy_ni` high) is sampled, the old grant clears and the winner's grant sets in that same update.
- R10: The parked owner may pull `bus_busy_ni` low without a new grant. Its grant stays in place through the transfer and after release when no one requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; all sampling on the rising edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_MASTERS | Active-high request, bit 0 = bridge, bits 1..3 = processors |
| bus_busy_ni | input | 1 | Shared bus-busy, low while the owner uses the bus |
| gnt_o | output | NUM_MASTERS | Active-high one-hot grant, one bit per master |

## Verification
The rotation is driven with all three processors requesting, then with gapped request sets that force the pointer to wrap from master 3 to master 1. A bench in which the pointer failed to advance or wrap shows up here. The bridge is made to request together with the processors, both while parked and on a release edge, with all processors pending. This separates a pointer that a bridge grant leaves alone from one it resets. Idle stretches with no requests show parking, and a parked owner's own transfer shows reuse without a new grant. A bridge request raised while a fresh processor grant waits for busy shows that the pending grant is not taken away.

// File: rtl/arb_pkg.sv
// Package: shared types for the hybrid bus arbiter.
// Assumes: master index 0 is the fixed-priority bridge port.
package arb_pkg;

    // Handoff sequencer state.
    typedef enum logic [1:0] {
        ST_PARK  = 2'd0,   // bus idle, grant parked on last owner
        ST_WAIT  = 2'd1,   // grant newly issued, waiting for busy to fall
        ST_OWNED = 2'd2    // owner is driving the bus (busy low seen)
    } arb_state_e;

    // Width of an index into n entries, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/arb_rr_picker.sv
// Module: rotating-priority picker.
// Searches N request bits starting at ptr_i and wrapping, and returns the
// first set bit. Assumes ptr_i is always below N.
module arb_rr_picker #(
    parameter int N  = 3,
    parameter int PW = arb_pkg::idx_width(N)
) (
    input  logic [N-1:0]  req_i,
    input  logic [PW-1:0] ptr_i,
    output logic          valid_o,
    output logic [PW-1:0] idx_o
);

    // Walk the candidates from the pointer onward and keep the first requester.
    always_comb begin
        int cand;
        valid_o = 1'b0;
        idx_o   = '0;
        for (int k = 0; k < N; k++) begin
            cand = int'(ptr_i) + k;
            if (cand >= N) cand = cand - N;
            if (!valid_o && req_i[cand]) begin
                valid_o = 1'b1;
                idx_o   = PW'(cand);
            end
        end
    end

endmodule

// File: rtl/arb_hybrid_select.sv
// Module: winner selection with a fixed top priority and rotation for the rest.
// Master 0 wins outright when it requests. Otherwise masters 1..NM-1 go
// through the rotating picker. Assumes NM >= 2.
module arb_hybrid_select #(
    parameter int NM  = 4,
    parameter int NRR = NM - 1,
    parameter int PW  = arb_pkg::idx_width(NRR)
) (
    input  logic [NM-1:0] req_i,
    input  logic [PW-1:0] ptr_i,
    output logic          valid_o,
    output logic [NM-1:0] onehot_o,
    output logic          is_rr_o,
    output logic [PW-1:0] rr_idx_o
);

    logic          rr_valid;
    logic [PW-1:0] rr_idx;

    arb_rr_picker #(.N(NRR), .PW(PW)) i_picker (
        .req_i   (req_i[NM-1:1]),
        .ptr_i   (ptr_i),
        .valid_o (rr_valid),
        .idx_o   (rr_idx)
    );

    // Combine the fixed-priority bridge with the rotating result.
    always_comb begin
        onehot_o = '0;
        is_rr_o  = 1'b0;
        rr_idx_o = rr_idx;
        valid_o  = req_i[0] | rr_valid;
        if (req_i[0]) begin
            onehot_o[0] = 1'b1;
        end else if (rr_valid) begin
            onehot_o[int'(rr_idx) + 1] = 1'b1;
            is_rr_o = 1'b1;
        end
    end

endmodule

// File: rtl/arb_handoff_ctrl.sv
// Module: grant register, rotation pointer and handoff sequencer.
// Moves the grant only at arbitration points: while parked and idle, or at the
// edge where the owner's release of busy is sampled. A fresh grant is held
// until busy falls. Assumes a granted master takes the bus.
module arb_handoff_ctrl
    import arb_pkg::*;
#(
    parameter int NM  = 4,
    parameter int NRR = NM - 1,
    parameter int PW  = idx_width(NRR)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          busy_ni,
    input  logic          win_valid_i,
    input  logic [NM-1:0] win_onehot_i,
    input  logic          win_is_rr_i,
    input  logic [PW-1:0] win_rr_idx_i,
    output logic [NM-1:0] gnt_o,
    output logic [PW-1:0] ptr_o,
    output arb_state_e    state_o
);

    arb_state_e    st_q, st_d;
    logic [NM-1:0] gnt_q, gnt_d;
    logic [PW-1:0] ptr_q, ptr_d;
    logic          decide;

    // Next-state, next-grant and next-pointer decision.
    always_comb begin
        st_d   = st_q;
        gnt_d  = gnt_q;
        ptr_d  = ptr_q;
        decide = 1'b0;
        case (st_q)
            ST_PARK: begin
                if (!busy_ni) begin
                    st_d = ST_OWNED;
                end else if (win_valid_i) begin
                    decide = 1'b1;
                    if (win_onehot_i != gnt_q) st_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!busy_ni) st_d = ST_OWNED;
            end
            ST_OWNED: begin
                if (busy_ni) begin
                    if (win_valid_i) begin
                        decide = 1'b1;
                        st_d   = ST_WAIT;
                    end else begin
                        st_d = ST_PARK;
                    end
                end
            end
            default: st_d = ST_PARK;
        endcase
        if (decide) begin
            gnt_d = win_onehot_i;
            if (win_is_rr_i) begin
                ptr_d = (win_rr_idx_i == PW'(NRR - 1)) ? '0 : win_rr_idx_i + PW'(1);
            end
        end
    end

    // State registers with synchronous reset to parked-on-bridge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q  <= ST_PARK;
            gnt_q <= NM'(1);
            ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            gnt_q <= gnt_d;
            ptr_q <= ptr_d;
        end
    end

    assign gnt_o   = gnt_q;
    assign ptr_o   = ptr_q;
    assign state_o = st_q;

    // R2: exactly one grant at all times.
    assert_one_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(gnt_q) == 1);

    // R3: grant frozen while the bus is busy.
    assert_hold_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_ni |=> $stable(gnt_q));

    // R8: a pending grant is not re-arbitrated before busy falls.
    assert_wait_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_WAIT && busy_ni) |=> $stable(gnt_q));

    // R6: a bridge win leaves the rotation pointer alone.
    assert_ptr_bridge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_valid_i && !win_is_rr_i) |=> $stable(ptr_q));

    // R5: pointer stays inside the rotating set.
    assert_ptr_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(ptr_q) < NRR);

endmodule

// File: rtl/hybrid_bus_arbiter.sv
// Module: top of the shared-bus arbiter.
// Master 0 is the bridge with fixed top priority; the others rotate. The grant
// moves only on busy release and parks on the last owner. Assumes requests and
// busy are synchronous to clk_i.
module hybrid_bus_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NUM_MASTERS-1:0] req_i,
    input  logic                   bus_busy_ni,
    output logic [NUM_MASTERS-1:0] gnt_o
);

    localparam int NRR = NUM_MASTERS - 1;
    localparam int PW  = idx_width(NRR);

    logic                   win_valid;
    logic [NUM_MASTERS-1:0] win_onehot;
    logic                   win_is_rr;
    logic [PW-1:0]          win_rr_idx;
    logic [PW-1:0]          ptr;
    arb_state_e             state;

    arb_hybrid_select #(.NM(NUM_MASTERS), .NRR(NRR), .PW(PW)) i_select (
        .req_i    (req_i),
        .ptr_i    (ptr),
        .valid_o  (win_valid),
        .onehot_o (win_onehot),
        .is_rr_o  (win_is_rr),
        .rr_idx_o (win_rr_idx)
    );

    arb_handoff_ctrl #(.NM(NUM_MASTERS), .NRR(NRR), .PW(PW)) i_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .busy_ni      (bus_busy_ni),
        .win_valid_i  (win_valid),
        .win_onehot_i (win_onehot),
        .win_is_rr_i  (win_is_rr),
        .win_rr_idx_i (win_rr_idx),
        .gnt_o        (gnt_o),
        .ptr_o        (ptr),
        .state_o      (state)
    );

    // R4: bridge wins at any arbitration point where it requests.
    assert_bridge_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_busy_ni && req_i[0] && state != ST_WAIT) |=> gnt_o[0]);

    // R7: with no requests and an idle bus the grant stays parked.
    assert_park_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_busy_ni && req_i == '0) |=> $stable(gnt_o));

endmodule

// File: tb/test_hybrid_bus_arbiter.sv
`timescale 1ns/1ps
module test_hybrid_bus_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = 4'b0000;
    logic       busy_n = 1'b1;
    logic [3:0] gnt;
    int         checks = 0;
    int         failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    hybrid_bus_arbiter #(.NUM_MASTERS(4)) i_hybrid_bus_arbiter (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_i       (req),
        .bus_busy_ni (busy_n),
        .gnt_o       (gnt)
    );

    task automatic expect_gnt(input string tag, input logic [3:0] exp);
        checks++;
        if (gnt !== exp) begin
            failures++;
            $display("FAIL %s gnt=%b expected=%b", tag, gnt, exp);
        end
    endtask

    // Apply inputs at a falling edge, pass one rising edge, land on the next falling edge.
    task automatic cyc(input logic [3:0] r, input logic b);
        req    = r;
        busy_n = b;
        @(negedge clk);
        checks++;
        if ($countones(gnt) != 1) begin
            failures++;
            $display("FAIL R2 gnt=%b expected=one-hot", gnt);
        end
    endtask

    task automatic t_reset();
        expect_gnt("R1 reset value", 4'b0001);
        cyc(4'b0000, 1'b1);
        expect_gnt("R1 parked after reset", 4'b0001);
    endtask

    task automatic t_rotation();
        cyc(4'b1110, 1'b1);
        expect_gnt("R1 R5 first processor", 4'b0010);
        cyc(4'b1100, 1'b0);
        expect_gnt("R3 hold while busy", 4'b0010);
        cyc(4'b1100, 1'b0);
        expect_gnt("R3 hold while busy", 4'b0010);
        cyc(4'b1100, 1'b1);
        expect_gnt("R9 handoff on release", 4'b0100);
        cyc(4'b1010, 1'b0);
        cyc(4'b1010, 1'b1);
        expect_gnt("R5 next after master 2", 4'b1000);
        cyc(4'b0010, 1'b0);
        cyc(4'b0010, 1'b1);
        expect_gnt("R5 wrap to master 1", 4'b0010);
    endtask

    task automatic t_parking();
        cyc(4'b0000, 1'b0);
        cyc(4'b0000, 1'b1);
        expect_gnt("R7 park on last owner", 4'b0010);
        for (int i = 0; i < 3; i++) begin
            cyc(4'b0000, 1'b1);
            expect_gnt("R7 stays parked", 4'b0010);
        end
        cyc(4'b0000, 1'b0);
        expect_gnt("R10 parked owner reuses bus", 4'b0010);
        cyc(4'b0000, 1'b1);
        expect_gnt("R10 still parked after reuse", 4'b0010);
    endtask

    task automatic t_bridge();
        cyc(4'b1101, 1'b1);
        expect_gnt("R4 bridge wins while parked", 4'b0001);
        cyc(4'b1110, 1'b0);
        cyc(4'b1110, 1'b1);
        expect_gnt("R6 pointer kept after bridge", 4'b0100);
        cyc(4'b1110, 1'b0);
        cyc(4'b1111, 1'b1);
        expect_gnt("R4 bridge wins on release", 4'b0001);
    endtask

    task automatic t_pending();
        cyc(4'b1110, 1'b0);
        cyc(4'b1110, 1'b1);
        expect_gnt("R5 R6 rotation resumes at master 3", 4'b1000);
        cyc(4'b0001, 1'b1);
        expect_gnt("R8 pending grant kept", 4'b1000);
        cyc(4'b0001, 1'b1);
        expect_gnt("R8 pending grant kept", 4'b1000);
        cyc(4'b0001, 1'b0);
        expect_gnt("R3 owner holds bus", 4'b1000);
        cyc(4'b0001, 1'b1);
        expect_gnt("R4 R9 bridge after release", 4'b0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rotation();
        t_parking();
        t_bridge();
        t_pending();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule